// File: doc/BRIEF.md
# Multi-Modulus Frequency Prescaler

This block divides a fast clock by one of four ratios: 32, 33, 47 or 48. A two-or-three cycle core counts input clocks, and a binary chain of divide-by-2 stages counts core cycles, for a fixed factor of 16 core cycles per output period. The ratio is set by two level inputs. `band_sel` picks the low pair (32/33) or the high pair (47/48). `mod_ctl` picks one ratio inside the pair.

Exactly one core cycle per output period, the last one before the chain wraps, is the odd cycle. In the low band it runs three input clocks when `mod_ctl` is 0, and the other fifteen run two. In the high band the control polarity is inverted: every core cycle runs three input clocks, and the odd cycle shortens to two when `mod_ctl` is 1.

The block runs on the input clock. Once per period it gives a one-cycle `pulse_o`, and it drives `div_o` from the top stage of the chain as a square-like divided clock. A core cycle takes its length at its start and keeps it to its end. A control change therefore takes effect at the next core boundary and can never cut a cycle short.

Top module: `mmp_prescaler`

## Requirements
- R1: While `rst` is high, and in the cycle after the last reset edge, `pulse_o` and `div_o` are both 0.
- R2: With `band_sel`=0 and `mod_ctl`=1 held steady, `pulse_o` repeats every 32 clocks.
- R3: With `band_sel`=0 and `mod_ctl`=0 held steady, `pulse_o` repeats every 33 clocks.
- R4: With `band_sel`=1 and `mod_ctl`=0 held steady, `pulse_o` repeats every 48 clocks.
- R5: With `band_sel`=1 and `mod_ctl`=1 held steady, `pulse_o` repeats every 47 clocks.
- R6: `pulse_o` is high for exactly one clock per period and is never high in two consecutive cycles.
- R7: `div_o` is high while the chain counts the last eight core cycles of a period (chain count 8 to 15). Over one period it is therefore high for 16, 17, 24 or 23 clocks for ratios 32, 33, 48 and 47.
- R8: Counting the first rising edge with `rst` low as edge 1, the first `pulse_o` appears after edge P, where P is the ratio set during reset.
- R9: The control inputs are sampled only at core-cycle boundaries. A core cycle is never shorter than 2 or longer than 3 clocks, and every period lies between 32 and 48 clocks. The first core cycle of a period uses the controls present at the boundary edge that ended the previous period. For example, switching from 32 to 48 just after a pulse gives one 47-clock period (2+15×3), then 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| band_sel | input | 1 | 0: 32/33 pair, 1: 47/48 pair |
| mod_ctl | input | 1 | Chooses the ratio within the selected pair |
| pulse_o | output | 1 | One-cycle pulse at the end of each division period |
| div_o | output | 1 | Divided clock from the top chain stage |

## Verification
The assertions assume that `band_sel` and `mod_ctl` are plain synchronous levels. They may change in any cycle, but they are sampled only at the edge that ends a core cycle. On that basis, a core length that stays fixed mid-cycle and a period bounded by 2N and 3N must hold for any input sequence.

The stimulus changes the controls on the falling edge of the clock. It holds them through reset so that the first core cycle sees the intended setting. It then switches them directly after an observed pulse, so that the mixed first period after a switch can be predicted exactly.

// File: rtl/mmp_pkg.sv
package mmp_pkg;

   // Decide whether the next core cycle lasts three input clocks.
   // odd : the next core cycle is the last one of the output period.
   // Low band: only the odd cycle stretches, and only when mod is low.
   // High band: control polarity inverted, every cycle is three long
   // except the odd one when mod is high.
   function automatic logic core_take3(input logic band, input logic modc,
                                       input logic odd);
      logic gate_lo;
      gate_lo = ~modc & odd;
      return band ? ~(modc & odd) : gate_lo;
   endfunction

endpackage

// File: rtl/mmp_gate.sv
module mmp_gate
   import mmp_pkg::*;
(
   input  logic band_sel,
   input  logic mod_ctl,
   input  logic odd_next,
   output logic take3
);

   always_comb take3 = core_take3(band_sel, mod_ctl, odd_next);

endmodule

// File: rtl/mmp_core23.sv
module mmp_core23 (
   input  logic clk,
   input  logic rst,
   input  logic take3_in,
   output logic cyc_end
);

   logic [1:0] cnt;
   logic       len3_q;

   assign cyc_end = (cnt == (len3_q ? 2'd2 : 2'd1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= 2'd0;
         len3_q <= take3_in;
      end else if (cyc_end) begin
         cnt    <= 2'd0;
         len3_q <= take3_in;
      end else begin
         cnt    <= cnt + 2'd1;
      end
   end

   // R9: the length chosen for a core cycle holds until that cycle ends
   p_len_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !cyc_end |=> $stable(len3_q));

   // R9: a core cycle never lasts longer than three clocks
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
      cnt != 2'd3);

endmodule

// File: rtl/mmp_chain.sv
module mmp_chain #(
   parameter int STAGES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [STAGES-1:0] idx
);

   logic [STAGES:0] carry;

   assign carry[0] = step;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      assign carry[i+1] = carry[i] & idx[i];
      always_ff @(posedge clk) begin
         if (rst)           idx[i] <= 1'b0;
         else if (carry[i]) idx[i] <= ~idx[i];
      end
   end

   // R7: the chain moves only at core-cycle boundaries
   p_chain_still_r7: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(idx));

   // R7: wrap back to zero after the last core cycle
   p_chain_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      (step && (&idx)) |=> (idx == '0));

endmodule

// File: rtl/mmp_prescaler.sv
module mmp_prescaler #(
   parameter int STAGES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic band_sel,
   input  logic mod_ctl,
   output logic pulse_o,
   output logic div_o
);

   localparam int NCYC   = 1 << STAGES;
   localparam int PW     = STAGES + 2;
   localparam int PMIN   = 2 * NCYC;
   localparam int PMAX   = 3 * NCYC;
   localparam logic [STAGES-1:0] LAST = '1;
   localparam logic [STAGES-1:0] PRE_LAST = LAST - 1'b1;

   if (STAGES < 1 || STAGES > 12) begin : g_bad_stages
      $error("mmp_prescaler: STAGES must be in 1..12");
   end

   logic              cyc_end;
   logic              take3;
   logic              odd_next;
   logic [STAGES-1:0] idx;
   logic              pulse_q;

   // the next core cycle is the odd one when the chain sits one before last
   if (STAGES == 1) begin : g_odd_one
      assign odd_next = ~rst & (idx == PRE_LAST);
   end else begin : g_odd_many
      assign odd_next = ~rst & (idx == PRE_LAST);
   end

   mmp_gate u_gate (
      .band_sel (band_sel),
      .mod_ctl  (mod_ctl),
      .odd_next (odd_next),
      .take3    (take3)
   );

   mmp_core23 u_core (
      .clk      (clk),
      .rst      (rst),
      .take3_in (take3),
      .cyc_end  (cyc_end)
   );

   mmp_chain #(.STAGES(STAGES)) u_chain (
      .clk  (clk),
      .rst  (rst),
      .step (cyc_end),
      .idx  (idx)
   );

   always_ff @(posedge clk) begin
      if (rst) pulse_q <= 1'b0;
      else     pulse_q <= cyc_end & (idx == LAST);
   end

   assign pulse_o = pulse_q;
   assign div_o   = idx[STAGES-1];

   // period watcher for the checks below
   logic [PW-1:0] per_cnt;
   always_ff @(posedge clk) begin
      if (rst)          per_cnt <= '0;
      else if (pulse_q) per_cnt <= PW'(1);
      else              per_cnt <= per_cnt + 1'b1;
   end

   // R6: the pulse lasts a single cycle
   p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);

   // R9: every period lies between 2N and 3N input clocks
   p_period_range_r9: assert property (@(posedge clk) disable iff (rst)
      pulse_o |-> (int'(per_cnt) >= PMIN && int'(per_cnt) <= PMAX));

   // R1: outputs are idle in the cycle after a reset edge
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (!pulse_o && !div_o));

endmodule

// File: tb/mmp_prescaler_test.sv
module mmp_prescaler_test;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic band_sel = 1'b0;
   logic mod_ctl = 1'b1;
   logic pulse_o, div_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmp_prescaler uut (
      .clk      (clk),
      .rst      (rst),
      .band_sel (band_sel),
      .mod_ctl  (mod_ctl),
      .pulse_o  (pulse_o),
      .div_o    (div_o)
   );

   // {band, mod, period[6:0], high count[6:0]}
   localparam logic [15:0] VEC [4] = '{
      {1'b0, 1'b1, 7'd32, 7'd16},
      {1'b0, 1'b0, 7'd33, 7'd17},
      {1'b1, 1'b0, 7'd48, 7'd24},
      {1'b1, 1'b1, 7'd47, 7'd23}
   };

   function automatic string tag_of(int i);
      case (i)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic b, logic m);
      @(negedge clk);
      rst = 1'b1; band_sel = b; mod_ctl = m;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // counts clocks until pulse_o is seen; also counts div_o high samples
   task automatic wait_pulse(output int edges, output int hi);
      edges = 0; hi = 0;
      forever begin
         @(negedge clk);
         edges++;
         if (div_o) hi++;
         if (pulse_o) break;
         if (edges > 400) begin
            n_checks++; n_fails++;
            $display("FAIL R6: no pulse within 400 clocks (actual %0d expected <=48)", edges);
            break;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: run hung (actual timeout, expected finish)");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int e, h;
      // R1: outputs idle during reset
      repeat (3) @(negedge clk);
      check("R1 pulse in reset", int'(pulse_o), 0);
      check("R1 div in reset",   int'(div_o),   0);

      for (int i = 0; i < 4; i++) begin
         do_reset(VEC[i][15], VEC[i][14]);
         wait_pulse(e, h);
         check($sformatf("R8 first period %s", tag_of(i)), e, int'(VEC[i][13:7]));
         wait_pulse(e, h);
         check($sformatf("%s period", tag_of(i)), e, int'(VEC[i][13:7]));
         check($sformatf("R7 div high count %s", tag_of(i)), h, int'(VEC[i][6:0]));
         // R6: pulse low in the cycle after it fires
         @(negedge clk);
         check("R6 pulse width", int'(pulse_o), 0);
      end

      // R9: switch 32 -> 48 right after a pulse: 2 + 15*3 then 48
      do_reset(1'b0, 1'b1);
      wait_pulse(e, h);
      band_sel = 1'b1; mod_ctl = 1'b0;
      wait_pulse(e, h);
      check("R9 mixed period 32->48", e, 47);
      wait_pulse(e, h);
      check("R9 settled period 48", e, 48);

      // R9: switch 48 -> 32 right after a pulse: 3 + 15*2 then 32
      band_sel = 1'b0; mod_ctl = 1'b1;
      wait_pulse(e, h);
      check("R9 mixed period 48->32", e, 33);

      // R9: 33 -> 32 switch: first core cycle is not the odd one, so 32 at once
      do_reset(1'b0, 1'b0);
      wait_pulse(e, h);
      mod_ctl = 1'b1;
      wait_pulse(e, h);
      check("R9 period 33->32", e, 32);

      // R1: reset mid-run clears outputs
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 pulse after mid reset", int'(pulse_o), 0);
      check("R1 div after mid reset",   int'(div_o),   0);
      rst = 1'b0;

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule